// File: doc/BRIEF.md
# Ethernet controller CSR bank

This block is the host-visible register bank of a simple Ethernet MAC. The host sees two 16-bit word locations. One is a data port. The other is a select port that picks which of four control/status registers the data port reaches. Register 0 carries the controller's run state, its latched event flags and the interrupt enable. Registers 1 and 2 hold the low and high halves of a 32-bit pointer to the initialization block in memory. Register 3 holds three bus-control bits.

The transmit engine, the receive engine and the media and memory error detectors report through single-cycle event pulses. The bank latches each pulse into an event flag. The host clears a flag by writing 1 to it. A write with the stop bit set returns register 0 to its reset value, whatever else the write carries. The init and start commands each set a group of status bits in one write. A level interrupt output is asserted while some interrupt source is pending and interrupts are enabled.

Top module: `eth_csr_bank`

## Requirements
- R1: After reset, register 0 reads 0x0004 (stop bit only), the select port reads 0, registers 1 to 3 are 0, `init_ptr_o` is 0 and `irq_o` is low.
- R2: A register 0 write with bit 2 set leaves register 0 at exactly 0x0004 and ignores all other written bits. Event pulses that arrive in the same cycle are also ignored.
- R3: On a register 0 write with bit 2 clear, a 1 in any of bits 14:8 clears that bit, and a 0 leaves it unchanged.
- R4: On a register 0 write with bit 2 clear, the interrupt-enable bit 6 takes the written value.
- R5: Writing bit 0 (init) sets the init-done bit 8 and the init bit 0, and clears stop. Otherwise, writing bit 1 (start) sets bit 1, the receiver-on bit 5 and the transmitter-on bit 4, and clears stop. When bits 0 and 1 are both written, only the init effect applies. Bits 5:4 and 1:0 are otherwise held until a stop.
- R6: Bit 15 reads as the OR of bits 14:11. Bit 7 reads as the OR of bit 15, bit 10, bit 9 and bit 8. Bit 3 always reads 0. Writes to bits 15, 7 and 3 have no effect.
- R7: `irq_o` is high exactly when bit 7 and bit 6 of register 0 are both set.
- R8: While the stop bit is clear, each pulse sets its flag in register 0: babble to bit 14, collision error to bit 13, missed frame to bit 12, memory error to bit 11, receive done to bit 10 and transmit done to bit 9. A set wins over a same-cycle write-one clear. While the stop bit is set, pulses are ignored.
- R9: A data-port write with select 1 loads `init_ptr_o[15:0]`. A data-port write with select 2 loads `init_ptr_o[31:16]`.
- R10: A data-port write with select 3 stores bits 2:0, driving `byte_swap_o` (bit 2), `ale_ctrl_o` (bit 1) and `byte_ctrl_o` (bit 0). Bits 15:3 of register 3 read 0.
- R11: A write to the select port loads select from `bus_wdata_i[1:0]`. A read with `bus_addr_i`=1 returns the select value zero-extended. A read with `bus_addr_i`=0 returns the register that select picks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 1 | Word offset: 0 data port, 1 select port |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the offset and current state |
| tx_done_i | input | 1 | Transmit done pulse |
| rx_done_i | input | 1 | Receive done pulse |
| babble_i | input | 1 | Transmit babble pulse |
| coll_err_i | input | 1 | Collision/heartbeat error pulse |
| miss_i | input | 1 | Missed frame pulse |
| mem_err_i | input | 1 | Memory error pulse |
| irq_o | output | 1 | Level interrupt |
| init_ptr_o | output | 32 | Initialization block pointer |
| byte_swap_o | output | 1 | Byte swap control |
| ale_ctrl_o | output | 1 | Address latch enable polarity control |
| byte_ctrl_o | output | 1 | Byte control |

## Verification
Every write and every event pulse takes effect at the rising edge on which it is presented. The new register contents, `irq_o`, `init_ptr_o` and the bus-control outputs are therefore visible one cycle later. The read data is combinational, so it follows a change of `bus_addr_i` within the same cycle. The bench drives each stimulus for one edge from the falling edge before it. It samples all results at the following falling edge, and it keeps a pulse that must be ignored on the same edge as the write it competes with.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
  localparam int DW   = 16;
  localparam int SELW = 2;
  localparam int PTRW = 32;
  localparam int BCW  = 3;
  localparam int EVW  = 6;

  // register 0 bit positions
  localparam int B_ERR  = 15;
  localparam int B_EVLO = 9;   // event flags occupy 14:9
  localparam int B_IDON = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  localparam logic [DW-1:0] CSR0_RST = DW'(1) << B_STOP;

  typedef enum logic [SELW-1:0] {
    SEL_CSR0 = 2'd0,
    SEL_PTRL = 2'd1,
    SEL_PTRH = 2'd2,
    SEL_BCTL = 2'd3
  } csr_sel_e;

  // order matches register 0 bits 14:9
  typedef struct packed {
    logic babble;
    logic coll;
    logic miss;
    logic mem_err;
    logic rx_done;
    logic tx_done;
  } evt_t;
endpackage

// File: rtl/eth_csr0_ctrl.sv
module eth_csr0_ctrl
  import eth_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  evt_t          evt_i,
  output logic [DW-1:0] csr0_o,
  output logic          irq_o
);
  logic [EVW-1:0] evt_q, evt_n;
  logic idon_q, idon_n, inea_q, inea_n, rxon_q, rxon_n, txon_q, txon_n;
  logic stop_q, stop_n, strt_q, strt_n, init_q, init_n;
  logic err, intr;

  always_comb begin
    evt_n  = evt_q;
    idon_n = idon_q;
    inea_n = inea_q;
    rxon_n = rxon_q;
    txon_n = txon_q;
    stop_n = stop_q;
    strt_n = strt_q;
    init_n = init_q;
    if (wr_i) begin
      evt_n  = evt_q & ~wdata_i[B_EVLO +: EVW];
      idon_n = idon_q & ~wdata_i[B_IDON];
      inea_n = wdata_i[B_INEA];
      if (wdata_i[B_INIT]) begin
        idon_n = 1'b1;
        init_n = 1'b1;
        stop_n = 1'b0;
      end else if (wdata_i[B_STRT]) begin
        strt_n = 1'b1;
        rxon_n = 1'b1;
        txon_n = 1'b1;
        stop_n = 1'b0;
      end
    end
    // set wins over write-one clear; engines are idle while stopped
    if (!stop_q) evt_n = evt_n | evt_i;
    if (wr_i && wdata_i[B_STOP]) begin
      evt_n  = '0;
      idon_n = 1'b0;
      inea_n = 1'b0;
      rxon_n = 1'b0;
      txon_n = 1'b0;
      stop_n = 1'b1;
      strt_n = 1'b0;
      init_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      idon_q <= 1'b0;
      inea_q <= 1'b0;
      rxon_q <= 1'b0;
      txon_q <= 1'b0;
      stop_q <= 1'b1;
      strt_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      evt_q  <= evt_n;
      idon_q <= idon_n;
      inea_q <= inea_n;
      rxon_q <= rxon_n;
      txon_q <= txon_n;
      stop_q <= stop_n;
      strt_q <= strt_n;
      init_q <= init_n;
    end
  end

  assign err  = |evt_q[EVW-1:2];
  assign intr = err | (|evt_q[1:0]) | idon_q;

  assign csr0_o = {err, evt_q, idon_q, intr, inea_q, rxon_q, txon_q, 1'b0,
                   stop_q, strt_q, init_q};
  assign irq_o  = intr & inea_q;
endmodule

// File: rtl/eth_csr_aux.sv
module eth_csr_aux
  import eth_csr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_sel_i,
  input  logic            wr_data_i,
  input  logic [DW-1:0]   wdata_i,
  output csr_sel_e        sel_o,
  output logic [PTRW-1:0] ptr_o,
  output logic [BCW-1:0]  bctl_o
);
  localparam int NHALF = PTRW / DW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_o <= SEL_CSR0;
    else if (wr_sel_i) sel_o <= csr_sel_e'(wdata_i[SELW-1:0]);
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ptr_o[h*DW +: DW] <= '0;
      else if (wr_data_i && sel_o == csr_sel_e'(SEL_PTRL + h))
        ptr_o[h*DW +: DW] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             bctl_o <= '0;
    else if (wr_data_i && sel_o == SEL_BCTL) bctl_o <= wdata_i[BCW-1:0];
  end
endmodule

// File: rtl/eth_csr_rdmux.sv
module eth_csr_rdmux
  import eth_csr_pkg::*;
(
  input  logic            addr_i,
  input  csr_sel_e        sel_i,
  input  logic [DW-1:0]   csr0_i,
  input  logic [PTRW-1:0] ptr_i,
  input  logic [BCW-1:0]  bctl_i,
  output logic [DW-1:0]   rdata_o
);
  always_comb begin
    if (addr_i) begin
      rdata_o = DW'(sel_i);
    end else begin
      unique case (sel_i)
        SEL_CSR0: rdata_o = csr0_i;
        SEL_PTRL: rdata_o = ptr_i[DW-1:0];
        SEL_PTRH: rdata_o = ptr_i[PTRW-1:DW];
        default:  rdata_o = DW'(bctl_i);
      endcase
    end
  end
endmodule

// File: rtl/eth_csr_bank.sv
module eth_csr_bank
  import eth_csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic        bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        tx_done_i,
  input  logic        rx_done_i,
  input  logic        babble_i,
  input  logic        coll_err_i,
  input  logic        miss_i,
  input  logic        mem_err_i,
  output logic        irq_o,
  output logic [31:0] init_ptr_o,
  output logic        byte_swap_o,
  output logic        ale_ctrl_o,
  output logic        byte_ctrl_o
);
  logic            wr_data, wr_sel, csr0_wr;
  csr_sel_e        sel;
  logic [DW-1:0]   csr0_val;
  logic [PTRW-1:0] ptr;
  logic [BCW-1:0]  bctl;
  evt_t            evt;

  assign wr_data = bus_we_i && !bus_addr_i;
  assign wr_sel  = bus_we_i && bus_addr_i;
  assign csr0_wr = wr_data && (sel == SEL_CSR0);

  assign evt = '{babble: babble_i, coll: coll_err_i, miss: miss_i,
                 mem_err: mem_err_i, rx_done: rx_done_i, tx_done: tx_done_i};

  eth_csr0_ctrl i_csr0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (csr0_wr),
    .wdata_i (bus_wdata_i),
    .evt_i   (evt),
    .csr0_o  (csr0_val),
    .irq_o   (irq_o)
  );

  eth_csr_aux i_aux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .wdata_i   (bus_wdata_i),
    .sel_o     (sel),
    .ptr_o     (ptr),
    .bctl_o    (bctl)
  );

  eth_csr_rdmux i_rdmux (
    .addr_i  (bus_addr_i),
    .sel_i   (sel),
    .csr0_i  (csr0_val),
    .ptr_i   (ptr),
    .bctl_i  (bctl),
    .rdata_o (bus_rdata_o)
  );

  assign init_ptr_o  = ptr;
  assign byte_swap_o = bctl[2];
  assign ale_ctrl_o  = bctl[1];
  assign byte_ctrl_o = bctl[0];
endmodule

// File: rtl/eth_csr_bank_chk.sv
module eth_csr_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        csr0_wr,
  input logic [15:0] bus_wdata_i,
  input logic [15:0] csr0_val,
  input logic        tx_done_i,
  input logic        irq_o
);
  AST_STOP_FORCES_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr0_wr && bus_wdata_i[2]) |=> (csr0_val == 16'h0004)); // R2

  AST_W1C_TINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr0_wr && !bus_wdata_i[2] && bus_wdata_i[9] && !tx_done_i) |=> !csr0_val[9]); // R3

  AST_INEA_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr0_wr && !bus_wdata_i[2]) |=> (csr0_val[6] == $past(bus_wdata_i[6]))); // R4

  AST_INIT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr0_wr && !bus_wdata_i[2] && bus_wdata_i[0]) |=> (csr0_val[8] && csr0_val[0] && !csr0_val[2])); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> csr0_val[6]); // R7

  AST_TX_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !csr0_val[2] && !(csr0_wr && bus_wdata_i[2])) |=> csr0_val[9]); // R8

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr0_val[2] && !csr0_wr) |=> $stable(csr0_val)); // R8
endmodule

bind eth_csr_bank eth_csr_bank_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr0_wr     (csr0_wr),
  .bus_wdata_i (bus_wdata_i),
  .csr0_val    (csr0_val),
  .tx_done_i   (tx_done_i),
  .irq_o       (irq_o)
);

// File: tb/test_eth_csr_bank.sv
module test_eth_csr_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic        bus_addr_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        tx_done_i = 1'b0, rx_done_i = 1'b0, babble_i = 1'b0;
  logic        coll_err_i = 1'b0, miss_i = 1'b0, mem_err_i = 1'b0;
  logic        irq_o;
  logic [31:0] init_ptr_o;
  logic        byte_swap_o, ale_ctrl_o, byte_ctrl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  eth_csr_bank i_eth_csr_bank (.*);

  // ev = {babble, coll, miss, mem_err, rx_done, tx_done}
  typedef struct packed {
    logic        we;
    logic [15:0] wd;
    logic [5:0]  ev;
    logic [15:0] exp;
    logic        irq;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0001, 6'h00, 16'h0181, 1'b0, "R5 "}, // init from stop
    '{1'b1, 16'h0042, 6'h00, 16'h01F3, 1'b1, "R7 "}, // enable + start
    '{1'b1, 16'h0140, 6'h00, 16'h0073, 1'b0, "R3 "}, // clear init-done
    '{1'b0, 16'h0000, 6'h01, 16'h02F3, 1'b1, "R8 "}, // tx done
    '{1'b1, 16'h0240, 6'h02, 16'h04F3, 1'b1, "R8 "}, // clear tx, rx arrives
    '{1'b1, 16'h0400, 6'h28, 16'hD0B3, 1'b0, "R6 "}, // babble+miss, enable off
    '{1'b1, 16'h1040, 6'h00, 16'hC0F3, 1'b1, "R3 "}, // clear miss only
    '{1'b1, 16'h6043, 6'h00, 16'h01F3, 1'b1, "R5 "}, // init and start together
    '{1'b1, 16'hFFFF, 6'h3F, 16'h0004, 1'b0, "R2 "}, // stop overrides all
    '{1'b0, 16'h0000, 6'h3F, 16'h0004, 1'b0, "R8 "}, // events while stopped
    '{1'b1, 16'h0000, 6'h01, 16'h0004, 1'b0, "R8 "}, // plain write, still stopped
    '{1'b1, 16'h0048, 6'h00, 16'h0044, 1'b0, "R4 "}, // enable, bit 3 not stored
    '{1'b1, 16'h8082, 6'h00, 16'h0032, 1'b0, "R6 "}, // bits 15/7 ignored, start
    '{1'b0, 16'h0000, 6'h14, 16'hA8B2, 1'b0, "R6 "}  // coll+mem error summary
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic addr, input logic [15:0] wd,
                     input logic [5:0] ev);
    bus_we_i    = we;
    bus_addr_i  = addr;
    bus_wdata_i = wd;
    {babble_i, coll_err_i, miss_i, mem_err_i, rx_done_i, tx_done_i} = ev;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_we_i = 1'b0;
    bus_addr_i = 1'b0;
    {babble_i, coll_err_i, miss_i, mem_err_i, rx_done_i, tx_done_i} = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    bus_addr_i = 1'b0; #1;
    check("R1", "csr0 reset", 32'(bus_rdata_o), 32'h0004);
    check("R1", "irq reset", 32'(irq_o), 32'h0);
    check("R1", "ptr reset", init_ptr_o, 32'h0);
    check("R1", "bctl reset", {29'd0, byte_swap_o, ale_ctrl_o, byte_ctrl_o}, 32'h0);
    bus_addr_i = 1'b1; #1;
    check("R1", "select reset", 32'(bus_rdata_o), 32'h0);
    bus_addr_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "csr0 after release", 32'(bus_rdata_o), 32'h0004);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].we, 1'b0, VEC[i].wd, VEC[i].ev);
      #1;
      check(string'(VEC[i].tag), $sformatf("vec %0d csr0", i), 32'(bus_rdata_o), 32'(VEC[i].exp));
      check(string'(VEC[i].tag), $sformatf("vec %0d irq", i), 32'(irq_o), 32'(VEC[i].irq));
    end

    // R9 pointer halves, R11 select read
    cyc(1'b1, 1'b1, 16'h0001, 6'h00);
    bus_addr_i = 1'b1; #1;
    check("R11", "select readback 1", 32'(bus_rdata_o), 32'h1);
    cyc(1'b1, 1'b0, 16'hBEEF, 6'h00);
    check("R9", "ptr low", init_ptr_o, 32'h0000BEEF);
    cyc(1'b1, 1'b1, 16'h0002, 6'h00);
    cyc(1'b1, 1'b0, 16'h1234, 6'h00);
    check("R9", "ptr full", init_ptr_o, 32'h1234BEEF);
    #1;
    check("R11", "data read csr2", 32'(bus_rdata_o), 32'h1234);

    // R10 bus control
    cyc(1'b1, 1'b1, 16'h0003, 6'h00);
    cyc(1'b1, 1'b0, 16'hFFFD, 6'h00);
    #1;
    check("R10", "csr3 read", 32'(bus_rdata_o), 32'h0005);
    check("R10", "bctl outputs", {29'd0, byte_swap_o, ale_ctrl_o, byte_ctrl_o}, 32'h5);
    check("R9", "ptr untouched by csr3", init_ptr_o, 32'h1234BEEF);

    // R11 upper select bits ignored
    cyc(1'b1, 1'b1, 16'hFFFE, 6'h00);
    bus_addr_i = 1'b1; #1;
    check("R11", "select masked", 32'(bus_rdata_o), 32'h2);
    bus_addr_i = 1'b0; #1;
    check("R11", "data read csr2 again", 32'(bus_rdata_o), 32'h1234);
    cyc(1'b1, 1'b1, 16'h0000, 6'h00);
    #1;
    check("R11", "csr0 untouched by aux writes", 32'(bus_rdata_o), 32'hA8B2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule